// File: doc/BRIEF.md
# Disturb-Assisted Ambiguous Cell Recovery Engine

This engine is started when the flash controller reports a page that its error correction could not decode. It first asks for the block's valid data to be copied elsewhere and waits until that copy is confirmed. It then takes a first quantized threshold-voltage reading of every cell of the failing page and stores it. Next it drives a programmable number of extra disturb reads at the page. Finally it takes a second reading of every cell.

Each cell's first reading is checked against an inclusive window set around a read reference. A cell inside the window is ambiguous, and its bit is decided from how far its reading rose between the two passes. A cell that moved a lot is treated as disturb-prone and placed in the higher-voltage state. A cell that moved little is treated as disturb-resistant and placed in the lower-voltage state. Cells outside the window keep the bit that was sensed for them. The corrected bits stream out during the second pass. At the end the engine reports how many bits it changed. The data copy, the voltage measurement and the final decode all sit outside the block, behind simple handshakes.

Top module: `rd_recovery_engine`

## Requirements
- R1: While idle, a high `uncorr_err_i` sampled on a clock edge makes `backup_req_o` go high after that edge. Nothing else starts the sequence.
- R2: `backup_req_o` stays high until `backup_ack_i` is sampled high. While it is high, `meas_req_o` and `disturb_req_o` stay low.
- R3: In the first measurement pass `meas_req_o` is high. The engine accepts exactly `NCELLS` readings, one on each cycle with `meas_valid_i` high, in cell order 0 upward. No `cell_valid_o` is produced during this pass.
- R4: After the first pass, `disturb_req_o` is held high until exactly `disturb_cnt_i` cycles with `disturb_ack_i` high have been counted. The count is 20 bits wide, and a value of 0 means 2^20. `meas_req_o` is low during this phase.
- R5: In the second pass, each accepted reading for cell i produces `cell_valid_o` high, with `cell_idx_o`=i and the corrected bit, in the cycle after it is accepted.
- R6: A cell is ambiguous when its first reading v satisfies `win_lo_i` <= v <= `win_hi_i`, with both bounds included.
- R7: For an ambiguous cell the shift is second minus first reading, and a negative difference counts as 0. If shift >= `shift_thr_i` (equal counts as large), the output bit is 0, which is the higher-voltage state. Otherwise the output bit is 1, the lower-voltage state.
- R8: A cell that is not ambiguous outputs the bit given with its first-pass reading (`meas_bit_i`) unchanged.
- R9: `done_o` is a one-cycle pulse in the same cycle as the last cell's output. `changed_cnt_o` then equals the number of output bits that differ from the first-pass sensed bit. It is cleared when a new sequence starts.
- R10: `uncorr_err_i` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uncorr_err_i | input | 1 | Uncorrectable error reported, starts recovery |
| win_lo_i | input | VW | Lower bound of the ambiguous window, inclusive |
| win_hi_i | input | VW | Upper bound of the ambiguous window, inclusive |
| shift_thr_i | input | VW | Shift at or above which a cell counts as disturb-prone |
| disturb_cnt_i | input | 20 | Number of disturb reads to issue (0 means 2^20) |
| backup_req_o | output | 1 | Request to copy the block's valid data |
| backup_ack_i | input | 1 | Copy complete |
| meas_req_o | output | 1 | Request for a threshold-voltage measurement pass |
| meas_valid_i | input | 1 | Streamed reading valid |
| meas_vth_i | input | VW | Quantized threshold reading |
| meas_bit_i | input | 1 | Originally sensed bit of the cell (used in the first pass) |
| disturb_req_o | output | 1 | Disturb reads requested |
| disturb_ack_i | input | 1 | One disturb read completed |
| cell_valid_o | output | 1 | Corrected bit valid |
| cell_idx_o | output | IW | Index of the corrected cell |
| cell_bit_o | output | 1 | Corrected bit |
| done_o | output | 1 | Recovery finished, one-cycle pulse |
| changed_cnt_o | output | CW | Number of bits changed by the recovery |

## Verification
Every result is due one clock edge after the stimulus that causes it. A request output follows one edge after the input that advances the sequence. A corrected bit appears one edge after its second-pass reading is accepted. `done_o` and the final change count appear on the same edge as the last corrected bit. The bench drives inputs on the falling edge and, at the next falling edge, compares each output against the value it has computed from the readings it supplied. Disturb acknowledges are counted in the bench until the request drops, and that count is compared with the programmed number. The checks cover shifts one below, equal to and one above the threshold, negative shifts, and cells on each window bound.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BACKUP, ST_MEAS0, ST_DISTURB, ST_MEAS1, ST_DONE
  } rdr_state_e;
  localparam int unsigned DCW = 20;
  localparam logic HI_STATE_BIT = 1'b0;  // higher Vth reads as 0
endpackage

// File: rtl/rdr_ctrl.sv
module rdr_ctrl import rdr_pkg::*; #(
  parameter int unsigned NCELLS = 16,
  localparam int unsigned IW = (NCELLS > 1) ? $clog2(NCELLS) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           uncorr_err_i,
  input  logic           backup_ack_i,
  input  logic           meas_valid_i,
  input  logic           disturb_ack_i,
  input  logic [DCW-1:0] disturb_target_i,
  output logic [IW-1:0]  idx_o,
  output logic           start_o,
  output logic           wr_en_o,
  output logic           cmp_en_o,
  output logic           backup_req_o,
  output logic           meas_req_o,
  output logic           disturb_req_o,
  output logic           done_o
);
  localparam logic [IW-1:0] LAST = IW'(NCELLS - 1);

  rdr_state_e     state_q;
  logic [IW-1:0]  idx_q;
  logic [DCW-1:0] dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:    if (uncorr_err_i) state_q <= ST_BACKUP;
        ST_BACKUP:  if (backup_ack_i) begin
          state_q <= ST_MEAS0;
          idx_q   <= '0;
        end
        ST_MEAS0:   if (meas_valid_i) begin
          idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          if (idx_q == LAST) begin
            state_q <= ST_DISTURB;
            dcnt_q  <= '0;
          end
        end
        ST_DISTURB: if (disturb_ack_i) begin
          // target 0 wraps to 2^20 reads
          if (dcnt_q == disturb_target_i - 1'b1) state_q <= ST_MEAS1;
          else dcnt_q <= dcnt_q + 1'b1;
        end
        ST_MEAS1:   if (meas_valid_i) begin
          idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ST_DONE;
        end
        ST_DONE:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o         = idx_q;
  assign start_o       = (state_q == ST_IDLE) && uncorr_err_i;
  assign wr_en_o       = (state_q == ST_MEAS0) && meas_valid_i;
  assign cmp_en_o      = (state_q == ST_MEAS1) && meas_valid_i;
  assign backup_req_o  = (state_q == ST_BACKUP);
  assign meas_req_o    = (state_q == ST_MEAS0) || (state_q == ST_MEAS1);
  assign disturb_req_o = (state_q == ST_DISTURB);
  assign done_o        = (state_q == ST_DONE);

  a_r1_start_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(backup_req_o) |-> $past(uncorr_err_i));
  a_r2_quiet_in_backup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_req_o |-> !meas_req_o && !disturb_req_o);
  a_r4_exact_disturbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disturb_req_o) |-> $past(disturb_ack_i) && ($past(dcnt_q) == $past(disturb_target_i) - 1'b1));
  a_r4_no_meas_in_disturb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disturb_req_o |-> !meas_req_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_ignores_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o || disturb_req_o) |=> !backup_req_o);
endmodule

// File: rtl/rdr_snap.sv
module rdr_snap #(
  parameter int unsigned NCELLS = 16,
  parameter int unsigned VW     = 8,
  localparam int unsigned IW = (NCELLS > 1) ? $clog2(NCELLS) : 1
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [VW-1:0] vth_i,
  input  logic          bit_i,
  output logic [VW-1:0] vth_o,
  output logic          bit_o
);
  logic [VW-1:0] vth_mem [NCELLS];
  logic [NCELLS-1:0] bit_mem;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      vth_mem[idx_i] <= vth_i;
      bit_mem[idx_i] <= bit_i;
    end
  end

  assign vth_o = vth_mem[idx_i];
  assign bit_o = bit_mem[idx_i];
endmodule

// File: rtl/rdr_classify.sv
module rdr_classify import rdr_pkg::*; #(
  parameter int unsigned VW = 8
) (
  input  logic [VW-1:0] before_i,
  input  logic [VW-1:0] after_i,
  input  logic          sensed_i,
  input  logic [VW-1:0] win_lo_i,
  input  logic [VW-1:0] win_hi_i,
  input  logic [VW-1:0] thr_i,
  output logic          bit_o,
  output logic          changed_o
);
  logic          in_win;
  logic [VW-1:0] shift;

  always_comb begin
    in_win = (before_i >= win_lo_i) && (before_i <= win_hi_i);
    shift  = (after_i > before_i) ? after_i - before_i : '0;
    if (!in_win)             bit_o = sensed_i;
    else if (shift >= thr_i) bit_o = HI_STATE_BIT;
    else                     bit_o = ~HI_STATE_BIT;
    changed_o = bit_o != sensed_i;
  end
endmodule

// File: rtl/rd_recovery_engine.sv
module rd_recovery_engine import rdr_pkg::*; #(
  parameter int unsigned NCELLS = 16,
  parameter int unsigned VW     = 8,
  localparam int unsigned IW = (NCELLS > 1) ? $clog2(NCELLS) : 1,
  localparam int unsigned CW = $clog2(NCELLS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           uncorr_err_i,
  input  logic [VW-1:0]  win_lo_i,
  input  logic [VW-1:0]  win_hi_i,
  input  logic [VW-1:0]  shift_thr_i,
  input  logic [DCW-1:0] disturb_cnt_i,
  output logic           backup_req_o,
  input  logic           backup_ack_i,
  output logic           meas_req_o,
  input  logic           meas_valid_i,
  input  logic [VW-1:0]  meas_vth_i,
  input  logic           meas_bit_i,
  output logic           disturb_req_o,
  input  logic           disturb_ack_i,
  output logic           cell_valid_o,
  output logic [IW-1:0]  cell_idx_o,
  output logic           cell_bit_o,
  output logic           done_o,
  output logic [CW-1:0]  changed_cnt_o
);
  logic [IW-1:0] idx;
  logic          start, wr_en, cmp_en;
  logic [VW-1:0] before_vth;
  logic          before_bit, corr_bit, corr_chg;

  rdr_ctrl #(.NCELLS(NCELLS)) u_ctrl (
    .clk_i, .rst_ni, .uncorr_err_i, .backup_ack_i, .meas_valid_i, .disturb_ack_i,
    .disturb_target_i(disturb_cnt_i),
    .idx_o(idx), .start_o(start), .wr_en_o(wr_en), .cmp_en_o(cmp_en),
    .backup_req_o, .meas_req_o, .disturb_req_o, .done_o
  );

  rdr_snap #(.NCELLS(NCELLS), .VW(VW)) u_snap (
    .clk_i, .wr_en_i(wr_en), .idx_i(idx), .vth_i(meas_vth_i), .bit_i(meas_bit_i),
    .vth_o(before_vth), .bit_o(before_bit)
  );

  rdr_classify #(.VW(VW)) u_cls (
    .before_i(before_vth), .after_i(meas_vth_i), .sensed_i(before_bit),
    .win_lo_i, .win_hi_i, .thr_i(shift_thr_i),
    .bit_o(corr_bit), .changed_o(corr_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_valid_o  <= 1'b0;
      cell_idx_o    <= '0;
      cell_bit_o    <= 1'b0;
      changed_cnt_o <= '0;
    end else begin
      cell_valid_o <= cmp_en;
      if (cmp_en) begin
        cell_idx_o <= idx;
        cell_bit_o <= corr_bit;
      end
      if (start)                   changed_cnt_o <= '0;
      else if (cmp_en && corr_chg) changed_cnt_o <= changed_cnt_o + 1'b1;
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_cnt_o <= CW'(NCELLS));
  a_r5_out_follows_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> $past(meas_req_o) && $past(meas_valid_i));
  a_r9_cnt_steady_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_req_o && !$past(meas_req_o) && !$past(uncorr_err_i)) |-> $stable(changed_cnt_o));
endmodule

// File: tb/rd_recovery_engine_bench.sv
`timescale 1ns/1ps
module rd_recovery_engine_bench;
  localparam int N = 16;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic uncorr_err = 0, backup_ack = 0, meas_valid = 0, meas_bit = 0, disturb_ack = 0;
  logic [VW-1:0] win_lo = 0, win_hi = 0, thr = 0, meas_vth = 0;
  logic [19:0] dcnt = 0;
  logic backup_req, meas_req, disturb_req, cell_valid, cell_bit, done;
  logic [3:0] cell_idx;
  logic [4:0] changed_cnt;

  rd_recovery_engine #(.NCELLS(N), .VW(VW)) u_rd_recovery_engine (
    .clk_i(clk), .rst_ni(rst_n), .uncorr_err_i(uncorr_err),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .shift_thr_i(thr), .disturb_cnt_i(dcnt),
    .backup_req_o(backup_req), .backup_ack_i(backup_ack),
    .meas_req_o(meas_req), .meas_valid_i(meas_valid), .meas_vth_i(meas_vth), .meas_bit_i(meas_bit),
    .disturb_req_o(disturb_req), .disturb_ack_i(disturb_ack),
    .cell_valid_o(cell_valid), .cell_idx_o(cell_idx), .cell_bit_o(cell_bit),
    .done_o(done), .changed_cnt_o(changed_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int bv[N], av[N], sb[N], eb[N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int seed, input int t, input int lo, input int hi,
                          input int nd, input bit poke_busy);
    int exp_chg, acks, wait_c;
    thr = VW'(t); win_lo = VW'(lo); win_hi = VW'(hi); dcnt = 20'(nd);
    exp_chg = 0;
    for (int i = 0; i < N; i++) begin
      int w, sh;
      w = hi - lo + 5;
      bv[i] = lo - 2 + ((i * 3 + seed) % w);
      if (bv[i] < 0) bv[i] = 0;
      sb[i] = (i + seed) % 2;
      if ((i + seed) % 7 == 0) av[i] = (bv[i] >= 3) ? bv[i] - 3 : 0;
      else av[i] = bv[i] + t + (i % 5) - 2;
      if (av[i] < 0) av[i] = 0;
      if (av[i] > 255) av[i] = 255;
      sh = (av[i] > bv[i]) ? av[i] - bv[i] : 0;
      if (bv[i] >= lo && bv[i] <= hi) eb[i] = (sh >= t) ? 0 : 1;
      else eb[i] = sb[i];
      if (eb[i] != sb[i]) exp_chg++;
    end
    @(negedge clk); uncorr_err = 1;
    @(negedge clk); uncorr_err = 0;
    chk(backup_req == 1, "R1 backup request after error", backup_req, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(backup_req == 1 && meas_req == 0 && disturb_req == 0, "R2 backup held, nothing else",
          {backup_req, meas_req, disturb_req}, 4);
    end
    backup_ack = 1;
    @(negedge clk); backup_ack = 0;
    chk(meas_req == 1 && backup_req == 0, "R3 first pass requested", meas_req, 1);
    for (int i = 0; i < N; i++) begin
      if (i > 0) chk(cell_valid == 0, "R3 no output in first pass", cell_valid, 0);
      meas_valid = 1; meas_vth = VW'(bv[i]); meas_bit = sb[i][0];
      @(negedge clk);
    end
    meas_valid = 0;
    acks = 0;
    while (disturb_req && acks < 200000) begin
      chk(meas_req == 0 && backup_req == 0, "R4 no meas during disturb", meas_req, 0);
      disturb_ack = 1;
      uncorr_err = poke_busy && (acks == 0);
      acks++;
      @(negedge clk);
      uncorr_err = 0;
    end
    disturb_ack = 0;
    chk(acks == nd, "R4 disturb read count", acks, nd);
    if (poke_busy) chk(backup_req == 0, "R10 error ignored when busy", backup_req, 0);
    wait_c = 0;
    while (!meas_req && wait_c < 10) begin @(negedge clk); wait_c++; end
    chk(meas_req == 1, "R5 second pass requested", meas_req, 1);
    for (int i = 0; i <= N; i++) begin
      if (i > 0) begin
        chk(cell_valid == 1 && int'(cell_idx) == i - 1, "R5 output one cycle later",
            int'(cell_idx), i - 1);
        chk(int'(cell_bit) == eb[i-1], "R6 R7 R8 corrected bit", int'(cell_bit), eb[i-1]);
        chk(done == (i == N), "R9 done timing", done, i == N);
      end
      if (i < N) begin
        meas_valid = 1; meas_vth = VW'(av[i]); meas_bit = 1'b0;
        @(negedge clk);
      end
    end
    meas_valid = 0;
    chk(int'(changed_cnt) == exp_chg, "R9 changed count", int'(changed_cnt), exp_chg);
    @(negedge clk);
    chk(done == 0 && cell_valid == 0, "R9 done single cycle", done, 0);
    chk(int'(changed_cnt) == exp_chg, "R9 count held", int'(changed_cnt), exp_chg);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(backup_req == 0 && meas_req == 0 && disturb_req == 0 && done == 0 && cell_valid == 0,
        "R1 reset idle", {backup_req, meas_req, disturb_req}, 0);
    chk(changed_cnt == 0, "R9 reset count", int'(changed_cnt), 0);
    repeat (4) @(negedge clk);
    chk(backup_req == 0, "R1 no start without error", backup_req, 0);
    run_case(0, 10, 40, 50, 1, 1'b0);
    run_case(3, 4, 100, 103, 3, 1'b1);
    run_case(5, 1, 0, 8, 7, 1'b0);
    run_case(2, 20, 200, 215, 2, 1'b1);
    run_case(6, 6, 60, 70, 100000, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule